// File: doc/BRIEF.md
# Three-Row Pixel Line Buffer

This block stores three image rows of 34 eight-bit pixels and presents them as a bank of 32 overlapping 3x3 neighbourhoods. A downstream bank of edge-detection operators consumes these neighbourhoods in parallel. A host drives bytes onto an 8-bit bus and qualifies each transfer with active-low strobes. Pixel bytes always enter the bottom row, one column at a time from the left. A command byte delivered with the mode strobe moves every row up by one line, so a fresh bottom row can be loaded.

The block counts how many complete rows it has received. It raises a valid flag once three full rows are resident. After that point, one shift and one fresh row give the next band of neighbourhoods. Reset clears all storage to zero, so the buffer starts blank before a computation begins.

Top module: `pix_row_buffer`

## Requirements
- R1: After reset every stored pixel reads 0x00, the write column is 0, and both `row_full` and `win_valid` are low.
- R2: A high-to-low transition of `data_stb_n` while `ready_n` and `rw_n` are both low writes `host_data` into the bottom row at the current write column. The column starts at 0 and advances by one per accepted byte. The result is visible one clock after the edge at which the strobe is first seen low.
- R3: A data strobe seen while `ready_n` or `rw_n` is high writes nothing and does not advance the column.
- R4: The write column saturates at 34. `row_full` is high while it equals 34, and further data strobes leave the rows unchanged.
- R5: A high-to-low transition of `mode_stb_n` with `host_data` equal to 0x66 moves the middle row to the top and the bottom row to the middle. It discards the old top row, clears the bottom row to zero, and returns the write column to 0.
- R6: A mode strobe carrying any other bus value changes neither the rows nor the write column.
- R7: Each strobe acts once per low period. Holding a strobe low for several clocks causes exactly one action.
- R8: Completed rows are counted up to 3. `win_valid` is high only while that count is 3 and the current bottom row is full. A shift drops it at once, and it rises again after the next full row.
- R9: Neighbourhood k (0 to 31) element (r, j) is row r (0 = top), column k+j. It is packed at bits [((k*9)+r*3+j)*8 +: 8] of `win_pix`.
- R10: When a shift command and an accepted data strobe arrive in the same clock, the shift takes effect and the data byte is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears all storage |
| host_data | input | 8 | Host bus byte: a pixel or a command code |
| ready_n | input | 1 | Active-low host ready; loading needs it low |
| rw_n | input | 1 | Active-low write direction; loading needs it low |
| data_stb_n | input | 1 | Active-low pixel strobe |
| mode_stb_n | input | 1 | Active-low command strobe |
| win_pix | output | 2304 | 32 neighbourhoods of nine pixels each |
| row_full | output | 1 | Bottom row holds 34 bytes |
| win_valid | output | 1 | Three complete rows are present |

## Verification
The assertions assume the bus and strobes are synchronous to `clk` and that `host_data` is stable during any clock in which a strobe is first seen low. They also assume that strobes idle high. The bench changes every input on the falling clock edge and sets the bus value in the same step as the strobe, so each action samples a settled byte. It releases each strobe before issuing the next one, except in the one test that fires both strobes together on purpose.

// File: rtl/pix_row_buffer.sv
module pix_row_buffer #(
  parameter int W = 8,
  parameter int COLS = 34,
  parameter logic [7:0] SHIFT_CODE = 8'h66
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [W-1:0] host_data,
  input  logic ready_n,
  input  logic rw_n,
  input  logic data_stb_n,
  input  logic mode_stb_n,
  output logic [(COLS-2)*9*W-1:0] win_pix,
  output logic row_full,
  output logic win_valid
);
  localparam int TAPS = COLS - 2;
  localparam int PW = $clog2(COLS + 1);
  localparam int RW = COLS * W;

  logic [RW-1:0] r_top, r_mid, r_bot;
  logic [PW-1:0] col_ptr;
  logic [1:0] fill;
  logic dstb_q, mstb_q;
  logic [RW-1:0] rows_all [3];

  wire data_ev  = dstb_q & ~data_stb_n & ~ready_n & ~rw_n;
  wire mode_ev  = mstb_q & ~mode_stb_n;
  wire shift_ev = mode_ev & (host_data[7:0] == SHIFT_CODE);
  wire full     = (col_ptr == PW'(COLS));
  wire wr_ev    = data_ev & ~shift_ev & ~full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dstb_q <= 1'b1;
      mstb_q <= 1'b1;
    end else begin
      dstb_q <= data_stb_n;
      mstb_q <= mode_stb_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_top <= '0;
      r_mid <= '0;
      r_bot <= '0;
      col_ptr <= '0;
      fill <= '0;
    end else if (shift_ev) begin
      r_top <= r_mid;
      r_mid <= r_bot;
      r_bot <= '0;
      col_ptr <= '0;
    end else if (wr_ev) begin
      r_bot[col_ptr*W +: W] <= host_data;
      col_ptr <= col_ptr + 1'b1;
      if (col_ptr == PW'(COLS - 1) && fill != 2'd3)
        fill <= fill + 1'b1;
    end
  end

  assign rows_all[0] = r_top;
  assign rows_all[1] = r_mid;
  assign rows_all[2] = r_bot;
  assign row_full  = full;
  assign win_valid = (fill == 2'd3) & full;

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    for (genvar r = 0; r < 3; r++) begin : g_row
      for (genvar j = 0; j < 3; j++) begin : g_col
        assign win_pix[((k*9)+r*3+j)*W +: W] = rows_all[r][(k+j)*W +: W];
      end
    end
  end

  // R4
  ptr_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_ptr <= PW'(COLS));

  // R5
  shift_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ev |=> (col_ptr == '0) && !win_valid);

  // R10
  shift_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_ev && data_ev) |=> (r_bot == '0));

  // R6
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ev && !shift_ev && !data_ev) |=>
      $stable(r_top) && $stable(r_mid) && $stable(r_bot) && $stable(col_ptr));

  // R3
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ready_n || rw_n) && !mode_ev) |=> $stable(r_bot) && $stable(col_ptr));

  // R7
  held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dstb_q && !data_stb_n && mstb_q && mode_stb_n) |=> $stable(col_ptr));
endmodule

// File: tb/pix_row_buffer_bench.sv
module pix_row_buffer_bench;
  localparam int COLS = 34;
  localparam int TAPS = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] host_data = '0;
  logic ready_n = 1'b0, rw_n = 1'b0, data_stb_n = 1'b1, mode_stb_n = 1'b1;
  logic [TAPS*9*8-1:0] win_pix;
  logic row_full, win_valid;

  int checks = 0, failures = 0;
  logic [7:0] m [3][COLS];
  int ptr = 0, fill = 0;

  always #2 clk = ~clk;

  pix_row_buffer u_pix_row_buffer (
    .clk(clk), .rst_n(rst_n), .host_data(host_data), .ready_n(ready_n),
    .rw_n(rw_n), .data_stb_n(data_stb_n), .mode_stb_n(mode_stb_n),
    .win_pix(win_pix), .row_full(row_full), .win_valid(win_valid));

  function automatic logic [7:0] get_pix(int r, int c);
    int k, j;
    if (c < TAPS) begin k = c; j = 0; end
    else begin k = TAPS - 1; j = c - (TAPS - 1); end
    return win_pix[((k*9)+r*3+j)*8 +: 8];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    int bad = 0;
    logic [7:0] ba = '0, be = '0;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < COLS; c++)
        if (get_pix(r, c) !== m[r][c]) begin
          if (bad == 0) begin ba = get_pix(r, c); be = m[r][c]; end
          bad++;
        end
    check({tag, " pixels"}, {24'd0, ba}, {24'd0, be});
    check({tag, " row_full"}, {31'd0, row_full}, {31'd0, ptr == COLS});
    check({tag, " win_valid"}, {31'd0, win_valid}, {31'd0, (fill == 3) && (ptr == COLS)});
  endtask

  task automatic model_byte(logic [7:0] b);
    if (!ready_n && !rw_n && ptr < COLS) begin
      m[2][ptr] = b;
      ptr++;
      if (ptr == COLS && fill < 3) fill++;
    end
  endtask

  task automatic model_shift();
    for (int c = 0; c < COLS; c++) begin
      m[0][c] = m[1][c]; m[1][c] = m[2][c]; m[2][c] = 8'h00;
    end
    ptr = 0;
  endtask

  task automatic send_byte(logic [7:0] b, int hold = 1);
    @(negedge clk);
    host_data = b; data_stb_n = 1'b0;
    repeat (hold) @(negedge clk);
    data_stb_n = 1'b1;
    model_byte(b);
  endtask

  task automatic send_mode(logic [7:0] b);
    @(negedge clk);
    host_data = b; mode_stb_n = 1'b0;
    @(negedge clk);
    mode_stb_n = 1'b1;
    if (b == 8'h66) model_shift();
  endtask

  task automatic load_row(int seed);
    for (int c = 0; c < COLS; c++) send_byte(8'((seed * 37 + c * 5 + 1) & 8'hff));
  endtask

  task automatic t_reset();
    for (int r = 0; r < 3; r++) for (int c = 0; c < COLS; c++) m[r][c] = 8'h00;
    ptr = 0; fill = 0;
    @(negedge clk);
    compare_all("R1");
  endtask

  task automatic t_load();
    for (int c = 0; c < 5; c++) send_byte(8'hA0 + 8'(c));
    @(negedge clk); compare_all("R2 partial");
    for (int c = 5; c < COLS; c++) send_byte(8'h10 + 8'(c));
    @(negedge clk); compare_all("R2 full row");
  endtask

  task automatic t_gate();
    send_mode(8'h66);
    rw_n = 1'b1; send_byte(8'h55); rw_n = 1'b0;
    @(negedge clk); compare_all("R3 rw_n high");
    ready_n = 1'b1; send_byte(8'h56); ready_n = 1'b0;
    @(negedge clk); compare_all("R3 ready_n high");
    send_byte(8'h57);
    @(negedge clk); compare_all("R3 enabled again");
  endtask

  task automatic t_saturate();
    for (int c = 1; c < COLS; c++) send_byte(8'h80 + 8'(c));
    @(negedge clk); compare_all("R4 at limit");
    send_byte(8'hEE); send_byte(8'hEF);
    @(negedge clk); compare_all("R4 beyond limit");
  endtask

  task automatic t_bad_code();
    send_mode(8'h65); @(negedge clk); compare_all("R6 code 0x65");
    send_mode(8'h00); @(negedge clk); compare_all("R6 code 0x00");
    send_mode(8'h67); @(negedge clk); compare_all("R6 code 0x67");
  endtask

  task automatic t_shift_and_held();
    send_mode(8'h66); @(negedge clk); compare_all("R5 shift");
    send_byte(8'h3C, 5); @(negedge clk); compare_all("R7 held data strobe");
    @(negedge clk);
    host_data = 8'h66; mode_stb_n = 1'b0;
    repeat (4) @(negedge clk);
    mode_stb_n = 1'b1;
    model_shift();
    @(negedge clk); compare_all("R7 held mode strobe");
  endtask

  task automatic t_valid();
    load_row(3); @(negedge clk); compare_all("R8 third row complete");
    check("R8 valid high", {31'd0, win_valid}, 32'd1);
    send_mode(8'h66); @(negedge clk); compare_all("R8 drop on shift");
    check("R8 valid low", {31'd0, win_valid}, 32'd0);
    load_row(4); @(negedge clk); compare_all("R8 next band");
    check("R8 valid again", {31'd0, win_valid}, 32'd1);
  endtask

  task automatic t_both();
    @(negedge clk);
    host_data = 8'h66; data_stb_n = 1'b0; mode_stb_n = 1'b0;
    @(negedge clk);
    data_stb_n = 1'b1; mode_stb_n = 1'b1;
    model_shift();
    @(negedge clk); compare_all("R10 shift wins");
  endtask

  task automatic t_windows();
    int bad = 0;
    load_row(9);
    @(negedge clk);
    for (int k = 0; k < TAPS; k++)
      for (int r = 0; r < 3; r++)
        for (int j = 0; j < 3; j++)
          if (win_pix[((k*9)+r*3+j)*8 +: 8] !== m[r][k+j]) bad++;
    check("R9 window mapping mismatches", bad, 0);
    check("R9 last tap corner", {24'd0, win_pix[((31*9)+8)*8 +: 8]}, {24'd0, m[2][33]});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load();
    t_gate();
    t_saturate();
    t_bad_code();
    t_shift_and_held();
    t_valid();
    t_both();
    t_windows();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule